// File: doc/BRIEF.md
# Eight-bit ALU with status flags

This block is the arithmetic and logic unit of a small 8-bit microcontroller datapath. It is purely combinational. Each cycle it takes a destination operand, a source operand (a second register or an immediate, chosen upstream), the current carry and zero flags and a 4-bit operation code. From these it produces an 8-bit result, a result write strobe and six status flags. A per-flag write enable tells the status register which flags this operation may change. Flags whose enable is low must be left alone by the consumer.

The supported operations are:
- add, add with carry, subtract and subtract with carry
- compare and compare with carry
- AND, OR and XOR
- clear-bits and set-bits masks
- one's complement and two's complement
- increment and decrement

The two compares compute a subtraction and report its flags, but raise no result write strobe. The carry-chained subtract and compare never set zero: they only clear it. Multi-byte values can then be subtracted or compared one byte at a time.

All pins carry plain control and data. The block holds no state and has no handshake, so the surrounding pipeline stage owns any flow control.

Top module: `alu8_core`

## Requirements
- R1: Operation code 0 gives a+b, and code 1 gives a+b+carry_i. For both, C is the carry out of bit 7, H is the carry out of bit 3, and V is set on signed overflow.
- R2: Code 2 gives a−b, and code 3 gives a−b−carry_i. C is set when the unsigned subtraction borrows, H is set on a borrow out of bit 3, and V is set on signed overflow.
- R3: For codes 3 (subtract with carry) and 5 (compare with carry), Z equals zero_i when the result is zero, and Z is 0 otherwise.
- R4: Codes 6, 7 and 8 give a AND b, a OR b and a XOR b. They write only Z, N, V and S, with V forced to 0.
- R5: Code 13 gives a AND NOT b (clear bits), and code 14 gives a OR b (set bits). Both follow the flag rules of R4.
- R6: Code 9 gives 0xFF−a. It writes C=1, V=0, Z, N and S, and it leaves H unwritten.
- R7: Code 10 gives 0x00−a and writes all six flags. C is set when a is nonzero, H is set when a[3:0] is nonzero, and V is set when a is 0x80.
- R8: Codes 4 and 5 compute a−b and a−b−carry_i with the flags of R2 (Z per R3 for code 5), and they hold result_we_o low.
- R9: Code 11 gives a+1, and code 12 gives a−1. Both write Z, N, V and S but never C or H. V is set when the result is 0x80 (increment) or 0x7F (decrement).
- R10: N is result bit 7, Z means an all-zero result (except as in R3), and S is N XOR V.
- R11: The flag vector bits are C=0, Z=1, N=2, V=3, S=4, H=5 in both flags_o and flags_we_o. Code 15 is reserved: it raises no result or flag write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (see requirements) |
| a_i | input | 8 | Destination operand |
| b_i | input | 8 | Source operand or immediate |
| carry_i | input | 1 | Current carry flag |
| zero_i | input | 1 | Current zero flag |
| result_o | output | 8 | Operation result |
| result_we_o | output | 1 | Result may be written back |
| flags_o | output | 6 | New flag values {H,S,V,N,Z,C} |
| flags_we_o | output | 6 | Per-flag write enable, same bit order |

## Verification
Every output is a function of the present inputs only, so all results are due in the same cycle that the stimulus is applied. The bench changes inputs on the falling clock edge and samples a quarter period later, well clear of the rising edge. It compares the result and write strobes, and it compares each flag only where the model says that flag is written. No check waits on a register, because the block has none.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_CMP  = 4'd4,
    OP_CMPC = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_INV  = 4'd9,
    OP_NEG  = 4'd10,
    OP_INC  = 4'd11,
    OP_DEC  = 4'd12,
    OP_CLRB = 4'd13,
    OP_SETB = 4'd14,
    OP_NOP  = 4'd15
  } alu_op_e;

  localparam int FL_C   = 0;
  localparam int FL_Z   = 1;
  localparam int FL_N   = 2;
  localparam int FL_V   = 3;
  localparam int FL_S   = 4;
  localparam int FL_H   = 5;
  localparam int NFLAGS = 6;

  typedef struct packed {
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;

  localparam logic [NFLAGS-1:0] WE_ALL   = 6'b111111;
  localparam logic [NFLAGS-1:0] WE_ZNVS  = 6'b011110;
  localparam logic [NFLAGS-1:0] WE_CZNVS = 6'b011111;
  localparam logic [NFLAGS-1:0] WE_NONE  = 6'b000000;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         use_carry_i,
  input  logic         carry_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         h_o,
  output logic         v_o
);
  localparam int HB = W / 2;

  logic [W-1:0] bx;
  logic         cin;
  logic [W:0]   full;
  logic [HB:0]  half;

  always_comb begin
    bx   = sub_i ? ~b_i : b_i;
    cin  = use_carry_i ? (sub_i ^ carry_i) : sub_i;
    full = {1'b0, a_i} + {1'b0, bx} + {{W{1'b0}}, cin};
    half = {1'b0, a_i[HB-1:0]} + {1'b0, bx[HB-1:0]} + {{HB{1'b0}}, cin};
    sum_o = full[W-1:0];
    c_o   = full[W] ^ sub_i;
    h_o   = half[HB] ^ sub_i;
    v_o   = (a_i[W-1] == bx[W-1]) && (full[W-1] != a_i[W-1]);
  end

  always_comb begin
    if (sub_i && !use_carry_i)
      assert_borrow_R2: assert (c_o == (a_i < b_i))
        else $error("borrow mismatch");
    if (!sub_i && !use_carry_i)
      assert_add_carry_R1: assert (c_o == ({1'b0, a_i} + {1'b0, b_i} > (2**W) - 1))
        else $error("carry mismatch");
  end
endmodule

// File: rtl/alu8_unary_logic.sv
module alu8_unary_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         v_o
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};

  always_comb begin
    res_o = '0;
    v_o   = 1'b0;
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_SETB: res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_CLRB: res_o = a_i & ~b_i;
      OP_INV:  res_o = ~a_i;
      OP_INC: begin
        res_o = a_i + ONE;
        v_o   = (res_o == SMIN);
      end
      OP_DEC: begin
        res_o = a_i - ONE;
        v_o   = (res_o == SMAX);
      end
      default: res_o = '0;
    endcase
  end

  always_comb begin
    if (op_i == OP_INV)
      assert_inv_value_R6: assert ((res_o ^ a_i) == {W{1'b1}})
        else $error("complement mismatch");
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OPW-1:0]    op_i,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic              carry_i,
  input  logic              zero_i,
  output logic [W-1:0]      result_o,
  output logic              result_we_o,
  output logic [NFLAGS-1:0] flags_o,
  output logic [NFLAGS-1:0] flags_we_o
);
  alu_op_e op;
  logic is_arith, is_sub, use_c, chain, is_neg;
  logic [W-1:0] add_a, add_b, sum, lres, res;
  logic ac, ah, av, lv;
  flags_t fl;

  assign op = alu_op_e'(op_i);

  always_comb begin
    is_neg   = (op == OP_NEG);
    is_arith = (op inside {OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP, OP_CMPC, OP_NEG});
    is_sub   = (op inside {OP_SUB, OP_SUBC, OP_CMP, OP_CMPC, OP_NEG});
    use_c    = (op inside {OP_ADDC, OP_SUBC, OP_CMPC});
    chain    = (op inside {OP_SUBC, OP_CMPC});
    add_a    = is_neg ? '0 : a_i;
    add_b    = is_neg ? a_i : b_i;
  end

  alu8_addsub #(.W(W)) u_addsub (
    .a_i(add_a), .b_i(add_b), .sub_i(is_sub), .use_carry_i(use_c),
    .carry_i(carry_i), .sum_o(sum), .c_o(ac), .h_o(ah), .v_o(av)
  );

  alu8_unary_logic #(.W(W)) u_logic (
    .op_i(op), .a_i(a_i), .b_i(b_i), .res_o(lres), .v_o(lv)
  );

  always_comb begin
    res  = is_arith ? sum : lres;
    fl   = '0;
    fl.n = res[W-1];
    fl.z = (res == '0) && (chain ? zero_i : 1'b1);
    fl.v = is_arith ? av : lv;
    fl.c = is_arith ? ac : (op == OP_INV);
    fl.h = is_arith ? ah : 1'b0;
    fl.s = fl.n ^ fl.v;
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP, OP_CMPC, OP_NEG: flags_we_o = WE_ALL;
      OP_AND, OP_OR, OP_XOR, OP_CLRB, OP_SETB, OP_INC, OP_DEC:   flags_we_o = WE_ZNVS;
      OP_INV:  flags_we_o = WE_CZNVS;
      default: flags_we_o = WE_NONE;
    endcase
    result_o    = res;
    flags_o     = fl;
    result_we_o = !(op inside {OP_CMP, OP_CMPC, OP_NOP});
  end

  always_comb begin
    if (op_i == 4'd4 || op_i == 4'd5)
      assert_cmp_no_write_R8: assert (!result_we_o) else $error("compare wrote result");
    if (op_i == 4'd3 || op_i == 4'd5)
      if (!zero_i)
        assert_zero_chain_R3: assert (!flags_o[FL_Z]) else $error("Z set in chain");
    if (op_i inside {4'd6, 4'd7, 4'd8, 4'd13, 4'd14})
      assert_logic_flags_R4: assert (!flags_o[FL_V] && !flags_we_o[FL_C] && !flags_we_o[FL_H])
        else $error("logic flag rule");
    if (op_i == 4'd11 || op_i == 4'd12)
      assert_keep_carry_R9: assert (!flags_we_o[FL_C]) else $error("inc/dec wrote C");
    if (result_we_o && flags_we_o[FL_N])
      assert_sign_bit_R10: assert (flags_o[FL_N] == result_o[W-1]) else $error("N mismatch");
    if (op_i == 4'd9)
      assert_inv_carry_R6: assert (flags_o[FL_C] && flags_we_o[FL_C] && !flags_o[FL_V])
        else $error("complement flags");
    if (op_i == 4'd15)
      assert_reserved_R11: assert (!result_we_o && flags_we_o == '0) else $error("reserved wrote");
  end
endmodule

// File: tb/alu8_core_test.sv
module alu8_core_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic [3:0] op;
  logic [7:0] a, b, res;
  logic cin, zin, rwe;
  logic [5:0] fl, fwe;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  alu8_core uut (
    .op_i(op), .a_i(a), .b_i(b), .carry_i(cin), .zero_i(zin),
    .result_o(res), .result_we_o(rwe), .flags_o(fl), .flags_we_o(fwe)
  );

  typedef struct packed {
    logic [7:0] r;
    logic       rwe;
    logic [5:0] f;
    logic [5:0] fwe;
  } exp_t;

  function automatic string tag_of(input int o);
    case (o)
      0, 1: return "R1";
      2, 3: return "R2";
      4, 5: return "R8";
      6, 7, 8: return "R4";
      9: return "R6";
      10: return "R7";
      11, 12: return "R9";
      13, 14: return "R5";
      default: return "R11";
    endcase
  endfunction

  function automatic exp_t model(input int o, input int x, input int y, input int c, input int z);
    exp_t e;
    int r, cf, hf, vf, zf;
    cf = 0; hf = 0; vf = 0;
    e.rwe = 1; e.fwe = 6'b011110;
    case (o)
      0, 1: begin
        if (o == 0) c = 0;
        r  = x + y + c;
        cf = (r > 255);
        hf = ((x & 15) + (y & 15) + c) > 15;
        vf = (((x ^ r) & (y ^ r) & 128) != 0);
        e.fwe = 6'b111111;
      end
      2, 3, 4, 5, 10: begin
        if (o == 10) begin y = x; x = 0; end
        if (o == 2 || o == 4 || o == 10) c = 0;
        r  = x - y - c;
        cf = (x < y + c);
        hf = ((x & 15) < (y & 15) + c);
        vf = (((x ^ y) & (x ^ r) & 128) != 0);
        e.fwe = 6'b111111;
        if (o == 4 || o == 5) e.rwe = 0;
      end
      6: r = x & y;
      7, 14: r = x | y;
      8: r = x ^ y;
      13: r = x & (255 - y);
      9: begin r = 255 - x; cf = 1; e.fwe = 6'b011111; end
      11: begin r = x + 1; vf = (x == 127); end
      12: begin r = x - 1; vf = (x == 128); end
      default: begin r = x; e.rwe = 0; e.fwe = 0; end
    endcase
    r = r & 255;
    zf = (r == 0);
    if (o == 3 || o == 5) zf = zf & z;
    e.r = r[7:0];
    e.f = {hf[0], r[7] ^ vf[0], vf[0], r[7], zf[0], cf[0]};
    return e;
  endfunction

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s op=%0d a=%h b=%h c=%0d z=%0d got=%h exp=%h",
               tag, what, op, a, b, cin, zin, got, exp);
    end
  endtask

  task automatic apply(input int o, input int x, input int y, input int c, input int z);
    exp_t e;
    @(negedge clk);
    op = o[3:0]; a = x[7:0]; b = y[7:0]; cin = c[0]; zin = z[0];
    #(PERIOD/4);
    e = model(o, x, y, c, z);
    if (e.rwe) chk(tag_of(o), "result", res, e.r);
    chk("R8", "result_we", rwe, e.rwe);
    chk("R11", "flags_we", fwe, e.fwe);
    chk((o == 3 || o == 5) ? "R3" : "R10", "flags", fl & e.fwe, e.f & e.fwe);
  endtask

  initial begin
    op = 0; a = 0; b = 0; cin = 0; zin = 0;
    #(PERIOD/4);
    chk("R10", "initial add 0+0 zero flag", fl[1], 1);
    // directed corners
    apply(0, 8'hFF, 8'h01, 0, 0);   // R1 wrap: C,H,Z
    apply(1, 8'h7F, 8'h00, 1, 0);   // R1 overflow via carry
    apply(2, 8'h80, 8'h01, 0, 0);   // R2 signed overflow
    apply(3, 8'h10, 8'h0F, 1, 0);   // R3 zero result, Z stays 0
    apply(3, 8'h10, 8'h0F, 1, 1);   // R3 zero result, Z kept 1
    apply(5, 8'h05, 8'h05, 0, 1);   // R3 R8
    apply(4, 8'h03, 8'h09, 0, 0);   // R8 borrow
    apply(9, 8'h00, 8'h00, 0, 0);   // R6
    apply(10, 8'h80, 8'h00, 0, 0);  // R7 V set
    apply(10, 8'h00, 8'h00, 1, 0);  // R7 C clear
    apply(11, 8'h7F, 8'h00, 1, 0);  // R9
    apply(12, 8'h80, 8'h00, 1, 0);  // R9
    apply(13, 8'hF0, 8'h30, 0, 0);  // R5
    apply(15, 8'h12, 8'h34, 1, 1);  // R11
    begin
      int seed = 32'h5EED;
      void'($urandom(seed));
      for (int i = 0; i < 3000; i++)
        apply($urandom_range(15, 0), $urandom_range(255, 0), $urandom_range(255, 0),
              $urandom_range(1, 0), $urandom_range(1, 0));
    end
    done = 1;
  end

  initial begin
    for (int t = 0; t < 100000 && !done; t++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule